// File: doc/BRIEF.md
# Speculative Single-Cycle Switch Allocator

This block schedules the output ports of a five-port mesh router with four virtual channels per input. In this router a flit crosses allocation and the crossbar in one clock. The allocator therefore has to hold each cycle's crossbar setting ready when that cycle begins. Requests that are already queued in the input virtual channels are arbitrated one cycle ahead. The winners sit in a grant register that drives the crossbar selects and the virtual-channel read strobes directly in the next cycle.

An output can be idle, meaning it has no registered grant and no queued request aimed at it. A flit arriving for an idle output is passed through in its arrival cycle with no arbitration. If two or more arrivals want the same idle output in that cycle, the pass is cancelled. None of those flits moves, and all of them join the queued requests, which take part in the next round of look-ahead arbitration. Each output keeps a credit count for its downstream buffer, and a flit may leave only while that count is nonzero.

The block does not include route computation, virtual-channel allocation, buffer storage, the crossbar datapath or clocking. Upstream logic must send an arrival only to a virtual channel that has no queued request.

Top module: `spec_sw_alloc`

## Requirements
- R1: After reset no crossbar select, read strobe or speculative flag is raised. No request is queued, every round-robin pointer is 0, and every output holds CRED_MAX credits.
- R2: An arrival passes through in its arrival cycle when four conditions all hold: its output is idle, no other arrival wants that output, that output has a credit, and its input holds no registered grant. In that cycle xbar_sel bit o*5+i, vc_rd bit i*4+v and spec_gnt bit o are all raised.
- R3: When two or more arrivals want the same idle output, none of them is passed in that cycle. All of them are queued, and no round-robin pointer moves.
- R4: A request queued in cycle t is arbitrated in cycle t and, if it wins, is granted in cycle t+1. Arbitration considers only the requests that remain after cycle t's grants. A request that arrives in cycle t is first arbitrated in cycle t+1.
- R5: An output that has a registered grant or a queued request is given no pass-through in that cycle, and the arrivals that want it are queued.
- R6: An arrival on an input that already holds a registered grant for this cycle is queued rather than passed through.
- R7: Each output picks among queued requests k = i*4+v by searching upward from its pointer, wrapping past 19. When a registered grant to k is used, the pointer of that output becomes (k+1) mod 20.
- R8: Each output is granted to at most one input per cycle, and each input to at most one output. Outputs are arbitrated in index order 0..4 (North=0, East=1, South=2, West=3, Local=4), and an input claimed by a lower-index output is skipped by the higher-index ones.
- R9: Every grant uses one credit of its output. A returned credit adds one, up to CRED_MAX. A pass-through needs a nonzero count. A look-ahead grant needs a count that is still nonzero after this cycle's own use, and returns arriving in the same cycle are not counted toward it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_vld | input | 5 | A new flit arrives at input i this cycle |
| arr_vc | input | 10 | Virtual channel of the arrival, 2 bits per input at i*2 |
| arr_dst | input | 15 | Requested output of the arrival, 3 bits per input at i*3 |
| cred_ret | input | 5 | One credit returned to output o |
| xbar_sel | output | 25 | Crossbar select, bit o*5+i connects input i to output o |
| vc_rd | output | 20 | Read strobe, bit i*4+v reads virtual channel v of input i |
| spec_gnt | output | 5 | Output o carries a pass-through flit this cycle |

## Verification
The first pattern is a lone arrival at an idle output, which separates the same-cycle pass-through from the one-cycle-late look-ahead path. Pairs of arrivals aimed at one idle output show that a cancelled pass drops no flit and produces grants in round-robin order rather than in fixed priority. Arrivals aimed at an output that still has queued work, or sent from an input that already holds a grant, show that queued requests win. One input with two virtual channels pending for two different outputs shows the one-output-per-input rule and the order in which outputs are arbitrated. A stream to one output with credit returns stopped shows the pass-through refused at zero credits and the look-ahead grant held back until a single return has been registered.

// File: rtl/spec_sw_alloc.sv
module spec_sw_alloc #(
  parameter int NP = 5,
  parameter int NV = 4,
  parameter int CRED_MAX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NP-1:0]      arr_vld,
  input  logic [NP*$clog2(NV)-1:0] arr_vc,
  input  logic [NP*$clog2(NP)-1:0] arr_dst,
  input  logic [NP-1:0]      cred_ret,
  output logic [NP*NP-1:0]   xbar_sel,
  output logic [NP*NV-1:0]   vc_rd,
  output logic [NP-1:0]      spec_gnt
);
  localparam int NR = NP * NV;
  localparam int PW = $clog2(NP);
  localparam int VW = $clog2(NV);
  localparam int RW = $clog2(NR);
  localparam int CW = $clog2(CRED_MAX + 1);

  logic [NR-1:0] pend, pend_left, pend_n, consumed;
  logic [PW-1:0] pend_dst [NR];
  logic [PW-1:0] pdst_n [NR];
  logic [NP-1:0] gv, ngv, held, busy, used, got, taken;
  logic [RW-1:0] gk [NP];
  logic [RW-1:0] ngk [NP];
  logic [RW-1:0] ptr [NP];
  logic [RW-1:0] ptr_n [NP];
  logic [CW-1:0] cred [NP];
  logic [CW-1:0] cred_n [NP];
  logic [PW-1:0] who [NP];
  logic [PW-1:0] adst [NP];
  logic [VW-1:0] avc [NP];

  always_comb
    for (int i = 0; i < NP; i++) begin
      adst[i] = arr_dst[i*PW +: PW];
      avc[i]  = arr_vc[i*VW +: VW];
    end

  // pass-through decision for idle outputs
  always_comb begin
    int cnt;
    held = '0;
    busy = gv;
    got = '0;
    for (int o = 0; o < NP; o++)
      if (gv[o]) held[int'(gk[o]) / NV] = 1'b1;
    for (int k = 0; k < NR; k++)
      for (int o = 0; o < NP; o++)
        if (pend[k] && pend_dst[k] == PW'(o)) busy[o] = 1'b1;
    for (int o = 0; o < NP; o++) begin
      cnt = 0;
      who[o] = '0;
      for (int i = 0; i < NP; i++)
        if (arr_vld[i] && adst[i] == PW'(o)) begin
          cnt = cnt + 1;
          who[o] = PW'(i);
        end
      spec_gnt[o] = (cnt == 1) && !busy[o] && (cred[o] != '0) && !held[who[o]];
      if (spec_gnt[o]) got[who[o]] = 1'b1;
    end
  end

  // look-ahead arbitration over requests that remain
  always_comb begin
    int k;
    consumed = '0;
    for (int o = 0; o < NP; o++)
      if (gv[o]) consumed[gk[o]] = 1'b1;
    pend_left = pend & ~consumed;
    used = gv | spec_gnt;
    taken = '0;
    ngv = '0;
    for (int o = 0; o < NP; o++) begin
      ngk[o] = '0;
      for (int j = 0; j < NR; j++) begin
        k = (int'(ptr[o]) + j) % NR;
        if (!ngv[o] && pend_left[k] && pend_dst[k] == PW'(o) && !taken[k / NV]
            && cred[o] > CW'(used[o])) begin
          ngv[o] = 1'b1;
          ngk[o] = RW'(k);
          taken[k / NV] = 1'b1;
        end
      end
    end
  end

  // queue update, pointer and credit next state
  always_comb begin
    int t;
    pend_n = pend_left;
    pdst_n = pend_dst;
    for (int i = 0; i < NP; i++)
      if (arr_vld[i] && !got[i]) begin
        pend_n[i*NV + int'(avc[i])] = 1'b1;
        pdst_n[i*NV + int'(avc[i])] = adst[i];
      end
    for (int o = 0; o < NP; o++) begin
      ptr_n[o] = gv[o] ? RW'((int'(gk[o]) + 1) % NR) : ptr[o];
      t = int'(cred[o]) + int'(cred_ret[o]) - int'(used[o]);
      if (t > CRED_MAX) t = CRED_MAX;
      cred_n[o] = CW'(t);
    end
  end

  always_comb begin
    xbar_sel = '0;
    vc_rd = consumed;
    for (int o = 0; o < NP; o++) begin
      if (gv[o]) xbar_sel[o*NP + int'(gk[o]) / NV] = 1'b1;
      if (spec_gnt[o]) begin
        xbar_sel[o*NP + int'(who[o])] = 1'b1;
        vc_rd[int'(who[o])*NV + int'(avc[who[o]])] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      pend <= '0;
      gv <= '0;
      for (int k = 0; k < NR; k++) pend_dst[k] <= '0;
      for (int o = 0; o < NP; o++) begin
        gk[o] <= '0;
        ptr[o] <= '0;
        cred[o] <= CW'(CRED_MAX);
      end
    end else begin
      pend <= pend_n;
      pend_dst <= pdst_n;
      gv <= ngv;
      gk <= ngk;
      ptr <= ptr_n;
      cred <= cred_n;
    end

  for (genvar go = 0; go < NP; go++) begin : g_out_chk
    // R8
    out_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(xbar_sel[go*NP +: NP]));
    // R4
    grant_was_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gv[go] |-> pend[gk[go]]);
    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gv[go] |=> $stable(ptr[go]));
    // R5
    queued_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spec_gnt[go] |-> !gv[go]);
    // R9
    cred_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cred[go] <= CW'(CRED_MAX));
  end

  for (genvar gi = 0; gi < NP; gi++) begin : g_in_chk
    logic [NP-1:0] col;
    always_comb
      for (int o = 0; o < NP; o++) col[o] = xbar_sel[o*NP + gi];
    // R8
    in_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
  end
endmodule

// File: tb/spec_sw_alloc_test.sv
`timescale 1ns/1ps
module spec_sw_alloc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]  arr_vld = '0;
  logic [9:0]  arr_vc = '0;
  logic [14:0] arr_dst = '0;
  logic [4:0]  cred_ret = '0;
  logic [24:0] xbar_sel;
  logic [19:0] vc_rd;
  logic [4:0]  spec_gnt;

  spec_sw_alloc uut (.clk(clk), .rst_n(rst_n), .arr_vld(arr_vld), .arr_vc(arr_vc),
    .arr_dst(arr_dst), .cred_ret(cred_ret), .xbar_sel(xbar_sel), .vc_rd(vc_rd),
    .spec_gnt(spec_gnt));

  always #2 clk = ~clk;

  typedef struct packed {
    logic [24:0] s;
    logic [19:0] r;
    logic [4:0]  p;
    logic [7:0]  req;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;
  logic [4:0] s_v = '0, ret_lvl = '1;
  logic [9:0] s_c = '0;
  logic [14:0] s_d = '0;

  function automatic logic [24:0] xs(int o, int i); return 25'd1 << (o*5 + i); endfunction
  function automatic logic [19:0] rv(int i, int v); return 20'd1 << (i*4 + v); endfunction
  function automatic logic [4:0] sb(int o); return 5'd1 << o; endfunction

  task automatic put(int i, int v, int d);
    s_v[i] = 1'b1;
    s_c[i*2 +: 2] = 2'(v);
    s_d[i*3 +: 3] = 3'(d);
  endtask

  task automatic step(logic [24:0] es, logic [19:0] er, logic [4:0] ep, int req);
    @(negedge clk);
    arr_vld = s_v; arr_vc = s_c; arr_dst = s_d; cred_ret = ret_lvl;
    q.push_back('{s: es, r: er, p: ep, req: 8'(req)});
    s_v = '0; s_c = '0; s_d = '0;
  endtask

  task automatic cmp(string what, int req, logic [24:0] act, logic [24:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp("xbar_sel", int'(e.req), xbar_sel, e.s);
      cmp("vc_rd", int'(e.req), 25'(vc_rd), 25'(e.r));
      cmp("spec_gnt", int'(e.req), 25'(spec_gnt), 25'(e.p));
    end
  end

  initial begin
    #40000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 quiet after reset
    step('0, '0, '0, 1);
    step('0, '0, '0, 1);
    // R2 lone arrival N vc1 -> East passes in its own cycle
    put(0, 1, 1); step(xs(1,0), rv(0,1), sb(1), 2);
    step('0, '0, '0, 2);
    // R3 two arrivals for idle South: cancelled, queued
    put(0, 0, 2); put(3, 2, 2); step('0, '0, '0, 3);
    // R4 arbitrated next cycle, granted the one after
    step('0, '0, '0, 4);
    // R5 Local arrival for busy South is queued
    put(4, 0, 2); step(xs(2,0), rv(0,0), '0, 5);
    step(xs(2,3), rv(3,2), '0, 4);
    step(xs(2,4), rv(4,0), '0, 5);
    // R7 pointer at 17: Local vc2 (18) beats North vc0 (0)
    put(0, 0, 2); put(4, 2, 2); step('0, '0, '0, 3);
    step('0, '0, '0, 7);
    step(xs(2,4), rv(4,2), '0, 7);
    step(xs(2,0), rv(0,0), '0, 7);
    // R8 input North pending to South and East; East claims it first
    put(0, 0, 2); put(4, 0, 2); step('0, '0, '0, 3);
    put(0, 1, 1); put(3, 1, 1); step('0, '0, '0, 3);
    step(xs(2,4), rv(4,0), '0, 7);
    // R6 North holds a grant: its arrival for idle West is queued
    put(0, 2, 3); step(xs(1,0), rv(0,1), '0, 8);
    step(xs(1,3) | xs(2,0), rv(3,1) | rv(0,0), '0, 8);
    step(xs(3,0), rv(0,2), '0, 6);
    step('0, '0, '0, 6);
    // R9 credit exhaustion on West
    ret_lvl = '0;
    for (int n = 0; n < 4; n++) begin
      put(0, 0, 3); step(xs(3,0), rv(0,0), sb(3), 9);
    end
    put(0, 2, 3); step('0, '0, '0, 9);
    ret_lvl = 5'b01000; step('0, '0, '0, 9);
    ret_lvl = '0; step('0, '0, '0, 9);
    step(xs(3,0), rv(0,2), '0, 9);
    ret_lvl = '1;
    step('0, '0, '0, 9);
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule